// File: doc/BRIEF.md
# Capture and External Count Input Stage

This block sits beside a free-running timer. It watches a set of asynchronous capture pins. Each pin passes through a synchroniser. The block then compares two consecutive clock samples of the pin to find rising and falling edges.

A detected edge has two possible uses. If a capture channel is enabled for that edge, the channel loads the timer value into its capture register and can raise a capture flag. If counter mode is selected, one chosen pin acts as the count source, and each selected edge on it produces a single-cycle count pulse for the timer.

The input toggle rate is limited to half the clock. Each high or low phase must last at least one clock period.

The timer value arrives on an input and is not counted here. Flags are cleared by a write-one-to-clear strobe into a shared flag register. The capture flags occupy bits 4 and up of that register.

Top module: `cap_cnt_in`

## Requirements
- R1: While reset is asserted and just after its release, every capture register reads 0, every capture flag reads 0, and `cnt_pulse_o` is 0.
- R2: The pin change must fall between two clock edges. At the third rising clock edge after the change, channel n loads `tmr_val_i` into `cap_val_o[n*32 +: 32]`, if the edge kind is enabled by `cap_rise_en_i[n]` or `cap_fall_en_i[n]`. An edge kind that is not enabled leaves the register unchanged.
- R3: A capture on channel n sets `cap_flag_o[n]` on the same edge only if `cap_irq_en_i[n]` is 1. If it is 0, the register still loads and the flag stays 0.
- R4: A `flag_wr_i` pulse clears `cap_flag_o[n]` when `flag_wdata_i[4+n]` is 1. Zero bits leave flags alone. A capture set on the same edge wins over the clear.
- R5: `cnt_mode_i` selects the counting mode:
  - 0 is timer mode, with no count pulses.
  - 1 counts rising edges.
  - 2 counts falling edges.
  - 3 counts both edges.
  Each counted edge makes `cnt_pulse_o` high for exactly one cycle. The pulse appears after the second rising clock edge following the pin change.
- R6: `cnt_sel_i` picks the count source. Value 0 selects pin 0 and value 1 selects pin 1. Values 2 and 3 select no pin, so no pulses are produced.
- R7: For the first three clock edges after reset release, no edge is reported, whatever the pin levels. A pin held high through reset yields no rising event.
- R8: A pin that toggles on every clock cycle has every transition detected. In mode 3 this gives one pulse per transition, back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cap_pin_i | input | 2 | Asynchronous capture pins |
| tmr_val_i | input | 32 | Running timer value |
| cnt_mode_i | input | 2 | Timer/counter mode select |
| cnt_sel_i | input | 2 | Count source pin select |
| cap_rise_en_i | input | 2 | Per-channel capture on rising edge |
| cap_fall_en_i | input | 2 | Per-channel capture on falling edge |
| cap_irq_en_i | input | 2 | Per-channel flag enable |
| flag_wr_i | input | 1 | Flag register write strobe |
| flag_wdata_i | input | 8 | Write-one-to-clear data, bit 4+n clears flag n |
| cap_val_o | output | 64 | Capture registers, channel n at bits n*32 +: 32 |
| cap_flag_o | output | 2 | Capture flags |
| cnt_pulse_o | output | 1 | One-cycle count pulse to the timer |

## Verification
The bench checks the exact clock edge of the pulse and of the capture. A design with one synchroniser stage too few or too many would load the timer value one cycle off, and the bench would see a different stamped value.

A pin held high through reset is a trap for a naive edge detector, which would report a phantom rising edge. The bench also lands a flag clear on the same edge as a capture; a design with the wrong priority would lose that event.

Pins toggling on every cycle in both-edge mode expose detectors that merge adjacent transitions. Random segments mix modes, reserved selector values and per-channel enables, and compare the pulse totals and stamped values against a bench model.

// File: rtl/cci_pkg.sv
`timescale 1ns/1ps
package cci_pkg;
  typedef enum logic [1:0] {
    CNT_OFF  = 2'd0,
    CNT_RISE = 2'd1,
    CNT_FALL = 2'd2,
    CNT_BOTH = 2'd3
  } cnt_mode_e;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;
endpackage

// File: rtl/cci_warmup.sv
`timescale 1ns/1ps
// Masks edge reports until the sample pair holds real pin values.
module cci_warmup #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic armed_o
);
  localparam int LIM = SYNC_STAGES + 1;
  localparam int CW  = $clog2(LIM + 1);

  logic [CW-1:0] cnt_q;

  assign armed_o = (cnt_q == CW'(LIM));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!armed_o) cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/cci_edge_det.sv
`timescale 1ns/1ps
module cci_edge_det
  import cci_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  pin_i,
  input  logic  armed_i,
  output edge_t edge_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   cur;

  assign cur = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      prev_q <= cur;
    end
  end

  assign edge_o.rise = armed_i &  cur & ~prev_q;
  assign edge_o.fall = armed_i & ~cur &  prev_q;
endmodule

// File: rtl/cci_cap_chan.sv
`timescale 1ns/1ps
module cci_cap_chan
  import cci_pkg::*;
#(
  parameter int TMR_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  edge_t            edge_i,
  input  logic             rise_en_i,
  input  logic             fall_en_i,
  input  logic             irq_en_i,
  input  logic             clr_i,
  input  logic [TMR_W-1:0] tmr_val_i,
  output logic [TMR_W-1:0] val_o,
  output logic             flag_o
);
  logic hit;

  assign hit = (edge_i.rise & rise_en_i) | (edge_i.fall & fall_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_o  <= '0;
      flag_o <= 1'b0;
    end else begin
      if (hit) val_o <= tmr_val_i;
      // a new event outranks a same-cycle clear
      if (hit && irq_en_i) flag_o <= 1'b1;
      else if (clr_i)      flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/cci_cnt_src.sv
`timescale 1ns/1ps
module cci_cnt_src
  import cci_pkg::*;
#(
  parameter int N_CAP = 2,
  parameter int SEL_W = 2
) (
  input  edge_t [N_CAP-1:0] edges_i,
  input  logic  [1:0]       mode_i,
  input  logic  [SEL_W-1:0] sel_i,
  output logic              pulse_o
);
  edge_t     src;
  cnt_mode_e mode;

  assign mode = cnt_mode_e'(mode_i);

  always_comb begin
    src = '0;
    for (int i = 0; i < N_CAP; i++) begin
      if (sel_i == SEL_W'(i)) src = edges_i[i];
    end
  end

  always_comb begin
    unique case (mode)
      CNT_RISE: pulse_o = src.rise;
      CNT_FALL: pulse_o = src.fall;
      CNT_BOTH: pulse_o = src.rise | src.fall;
      default:  pulse_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cap_cnt_in.sv
`timescale 1ns/1ps
module cap_cnt_in
  import cci_pkg::*;
#(
  parameter int TMR_W       = 32,
  parameter int N_CAP       = 2,
  parameter int SYNC_STAGES = 2,
  parameter int SEL_W       = 2,
  parameter int FLAG_W      = 8,
  parameter int FLAG_BASE   = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_CAP-1:0]       cap_pin_i,
  input  logic [TMR_W-1:0]       tmr_val_i,
  input  logic [1:0]             cnt_mode_i,
  input  logic [SEL_W-1:0]       cnt_sel_i,
  input  logic [N_CAP-1:0]       cap_rise_en_i,
  input  logic [N_CAP-1:0]       cap_fall_en_i,
  input  logic [N_CAP-1:0]       cap_irq_en_i,
  input  logic                   flag_wr_i,
  input  logic [FLAG_W-1:0]      flag_wdata_i,
  output logic [N_CAP*TMR_W-1:0] cap_val_o,
  output logic [N_CAP-1:0]       cap_flag_o,
  output logic                   cnt_pulse_o
);
  localparam int FLAG_TOP = FLAG_BASE + N_CAP;

  edge_t [N_CAP-1:0] edges;
  logic              armed;
  logic [N_CAP-1:0]  clr;
  logic              unused_wdata;

  assign unused_wdata = ^{flag_wdata_i[FLAG_BASE-1:0], flag_wdata_i[FLAG_W-1:FLAG_TOP]};

  cci_warmup #(.SYNC_STAGES(SYNC_STAGES)) u_warm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .armed_o (armed)
  );

  for (genvar i = 0; i < N_CAP; i++) begin : g_ch
    assign clr[i] = flag_wr_i & flag_wdata_i[FLAG_BASE+i];

    cci_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .pin_i   (cap_pin_i[i]),
      .armed_i (armed),
      .edge_o  (edges[i])
    );

    cci_cap_chan #(.TMR_W(TMR_W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .edge_i    (edges[i]),
      .rise_en_i (cap_rise_en_i[i]),
      .fall_en_i (cap_fall_en_i[i]),
      .irq_en_i  (cap_irq_en_i[i]),
      .clr_i     (clr[i]),
      .tmr_val_i (tmr_val_i),
      .val_o     (cap_val_o[i*TMR_W +: TMR_W]),
      .flag_o    (cap_flag_o[i])
    );
  end

  cci_cnt_src #(.N_CAP(N_CAP), .SEL_W(SEL_W)) u_src (
    .edges_i (edges),
    .mode_i  (cnt_mode_i),
    .sel_i   (cnt_sel_i),
    .pulse_o (cnt_pulse_o)
  );
endmodule

// File: rtl/cci_checker.sv
`timescale 1ns/1ps
module cci_checker #(
  parameter int TMR_W       = 32,
  parameter int N_CAP       = 2,
  parameter int SYNC_STAGES = 2,
  parameter int SEL_W       = 2,
  parameter int FLAG_W      = 8,
  parameter int FLAG_BASE   = 4
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [1:0]             cnt_mode_i,
  input logic [SEL_W-1:0]       cnt_sel_i,
  input logic [N_CAP-1:0]       cap_rise_en_i,
  input logic [N_CAP-1:0]       cap_fall_en_i,
  input logic [N_CAP-1:0]       cap_irq_en_i,
  input logic                   flag_wr_i,
  input logic [FLAG_W-1:0]      flag_wdata_i,
  input logic [N_CAP*TMR_W-1:0] cap_val_o,
  input logic [N_CAP-1:0]       cap_flag_o,
  input logic                   cnt_pulse_o
);
  logic [7:0] since_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                since_q <= '0;
    else if (since_q != 8'hFF)  since_q <= since_q + 8'd1;
  end

  p_warmup_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_q <= 8'(SYNC_STAGES)) |-> !cnt_pulse_o);

  p_pulse_needs_mode_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_pulse_o |-> (cnt_mode_i != 2'd0));

  p_pulse_needs_pin_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_pulse_o |-> (cnt_sel_i < SEL_W'(N_CAP)));

  p_rise_not_twice_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_pulse_o && cnt_mode_i == 2'd1) |=>
      !(cnt_pulse_o && cnt_mode_i == 2'd1 && $stable(cnt_sel_i)));

  for (genvar i = 0; i < N_CAP; i++) begin : g_chk
    p_cap_needs_en_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(cap_val_o[i*TMR_W +: TMR_W]) |-> $past(cap_rise_en_i[i] | cap_fall_en_i[i]));

    p_flag_needs_irq_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(cap_flag_o[i]) |-> $past(cap_irq_en_i[i]));

    p_flag_fall_by_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(cap_flag_o[i]) |-> $past(flag_wr_i && flag_wdata_i[FLAG_BASE+i]));
  end
endmodule

bind cap_cnt_in cci_checker #(
  .TMR_W(TMR_W), .N_CAP(N_CAP), .SYNC_STAGES(SYNC_STAGES),
  .SEL_W(SEL_W), .FLAG_W(FLAG_W), .FLAG_BASE(FLAG_BASE)
) u_chk (.*);

// File: tb/cap_cnt_in_tb.sv
`timescale 1ns/1ps
module cap_cnt_in_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  pin = '0;
  logic [31:0] tmr_val = '0;
  logic [1:0]  mode = '0;
  logic [1:0]  sel = '0;
  logic [1:0]  rise_en = '0, fall_en = '0, irq_en = '0;
  logic        fwr = 1'b0;
  logic [7:0]  fdata = '0;
  logic [63:0] cap_val;
  logic [1:0]  cap_flag;
  logic        pulse;

  int checks = 0, errors = 0, n = 0, pulse_cnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cap_cnt_in u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cap_pin_i(pin), .tmr_val_i(tmr_val),
    .cnt_mode_i(mode), .cnt_sel_i(sel), .cap_rise_en_i(rise_en),
    .cap_fall_en_i(fall_en), .cap_irq_en_i(irq_en), .flag_wr_i(fwr),
    .flag_wdata_i(fdata), .cap_val_o(cap_val), .cap_flag_o(cap_flag),
    .cnt_pulse_o(pulse)
  );

  always @(negedge clk) if (pulse) pulse_cnt++;

  function automatic logic [31:0] tv(int k);
    return 32'h1357_0000 + 32'(k) * 32'd977;
  endfunction

  function automatic logic [31:0] capv(int ch);
    return cap_val[ch*32 +: 32];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    n++;
    tmr_val = tv(n);
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) step();
  endtask

  // four transitions on one pin, spaced three cycles apart
  task automatic pattern4(input int p, output int cnt);
    int base;
    base = pulse_cnt;
    for (int i = 0; i < 4; i++) begin
      step(); pin[p] = ~pin[p];
      idle(2);
    end
    idle(4);
    cnt = pulse_cnt - base;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=timeout exp=finish");
    finish_run();
  end

  initial begin
    int m, c, base;
    void'($urandom(32'd7321));

    // reset with pin0 held high, rise counting armed
    pin = 2'b01; mode = 2'd1; sel = 2'd0; rise_en = 2'b01; irq_en = 2'b01;
    idle(3);
    chk("R1 cap during reset", cap_val[31:0] | cap_val[63:32], 32'd0);
    rst_n = 1'b1;
    chk("R1 flags after reset", {30'd0, cap_flag}, 32'd0);
    chk("R1 pulse after reset", {31'd0, pulse}, 32'd0);
    idle(6);
    chk("R7 no phantom rise pulses", pulse_cnt, 0);
    chk("R7 no phantom capture", capv(0), 32'd0);
    chk("R7 no phantom flag", {31'd0, cap_flag[0]}, 32'd0);

    // falling edge with only rise enabled
    step(); pin[0] = 1'b0;
    idle(4);
    chk("R2 disabled edge keeps register", capv(0), 32'd0);
    chk("R5 rise mode ignores fall", pulse_cnt, 0);

    // rising edge: exact pulse and capture timing
    step(); pin[0] = 1'b1; m = n;
    step();
    chk("R5 no pulse after first edge", {31'd0, pulse}, 32'd0);
    step();
    chk("R5 pulse after second edge", {31'd0, pulse}, 32'd1);
    step();
    chk("R5 pulse lasts one cycle", {31'd0, pulse}, 32'd0);
    chk("R2 capture stamp", capv(0), tv(m + 2));
    chk("R3 flag set with irq enable", {31'd0, cap_flag[0]}, 32'd1);

    // channel 1 capture without flag enable
    rise_en = 2'b11;
    step(); pin[1] = 1'b1; m = n;
    idle(4);
    chk("R3 capture without irq enable", capv(1), tv(m + 2));
    chk("R3 flag stays clear", {31'd0, cap_flag[1]}, 32'd0);

    // clears
    step(); fwr = 1'b1; fdata = 8'h0F;
    step(); fwr = 1'b0;
    chk("R4 zero bits do not clear", {31'd0, cap_flag[0]}, 32'd1);
    fwr = 1'b1; fdata = 8'h10;
    step(); fwr = 1'b0;
    chk("R4 clear by bit 4", {31'd0, cap_flag[0]}, 32'd0);

    // clear on the same edge as a new capture
    step(); pin[0] = 1'b0; idle(3);
    step(); pin[0] = 1'b1; m = n;
    step();
    step(); fwr = 1'b1; fdata = 8'h10;
    step(); fwr = 1'b0;
    chk("R4 set wins over clear", {31'd0, cap_flag[0]}, 32'd1);
    chk("R4 stamp on collision", capv(0), tv(m + 2));

    // mode sweep on pin0 (four transitions: two falls, two rises)
    rise_en = '0; fall_en = '0; irq_en = '0;
    mode = 2'd0; pattern4(0, c); chk("R5 timer mode no pulses", c, 0);
    mode = 2'd1; pattern4(0, c); chk("R5 rising count", c, 2);
    mode = 2'd2; pattern4(0, c); chk("R5 falling count", c, 2);
    mode = 2'd3; pattern4(0, c); chk("R5 both-edge count", c, 4);

    // source selection
    sel = 2'd1; pattern4(0, c); chk("R6 other pin ignored", c, 0);
    pattern4(1, c); chk("R6 pin1 selected", c, 4);
    sel = 2'd2; pattern4(0, c); chk("R6 reserved select 2", c, 0);
    sel = 2'd3; pattern4(1, c); chk("R6 reserved select 3", c, 0);

    // toggle on every cycle
    sel = 2'd0; mode = 2'd3; base = pulse_cnt;
    for (int i = 0; i < 8; i++) begin step(); pin[0] = ~pin[0]; end
    idle(4);
    chk("R8 every transition counted", pulse_cnt - base, 8);
    mode = 2'd1; base = pulse_cnt;
    for (int i = 0; i < 8; i++) begin step(); pin[0] = ~pin[0]; end
    idle(4);
    chk("R8 fast rises counted", pulse_cnt - base, 4);

    // random segments
    for (int s = 0; s < 40; s++) begin
      logic [31:0] ecap [2];
      logic [1:0]  hit;
      int          epulse;
      mode = 2'($urandom); sel = 2'($urandom);
      rise_en = 2'($urandom); fall_en = 2'($urandom); irq_en = 2'($urandom);
      step(); fwr = 1'b1; fdata = 8'h30;
      step(); fwr = 1'b0;
      ecap[0] = capv(0); ecap[1] = capv(1);
      hit = '0; epulse = 0; base = pulse_cnt;
      for (int t = 0; t < 40; t++) begin
        step();
        for (int p = 0; p < 2; p++) begin
          if ($urandom_range(2) == 0) begin
            bit rise;
            pin[p] = ~pin[p];
            rise = pin[p];
            if ((rise && rise_en[p]) || (!rise && fall_en[p])) begin
              ecap[p] = tv(n + 2);
              hit[p] = 1'b1;
            end
            if (sel == 2'(p) &&
                ((mode == 2'd1 && rise) || (mode == 2'd2 && !rise) || mode == 2'd3))
              epulse++;
          end
        end
      end
      idle(4);
      chk("R5 R6 random pulse total", pulse_cnt - base, epulse);
      chk("R2 random stamp ch0", capv(0), ecap[0]);
      chk("R2 random stamp ch1", capv(1), ecap[1]);
      chk("R3 random flags", {30'd0, cap_flag}, {30'd0, hit & irq_en});
    end

    finish_run();
  end
endmodule